// File: doc/BRIEF.md
# Five-Way System Bus Arbiter with Preference, Deny and Timeout

The block decides which of five bus masters owns a shared system bus. The masters are a processor, two graphics channels, a core I/O bus and an expansion bus. Each master raises a request line. The arbiter answers with a one-hot grant and holds that grant until the owner pulses `done`. One write-only control word configures the arbiter. The word holds a deny bit for each of the four non-processor masters, a preference bit for all five masters, and a 13-bit bus-error timeout.

Deny bits come out of reset set, so after reset only the processor can own the bus until software enables the others. Grants normally rotate round-robin among eligible requesters. When one master holds preference, it wins every other arbitration, provided it is requesting and not denied. A transaction that runs longer than the programmed number of clocks is cut off. The cut-off also raises a sticky status flag, which clears when it is read.

Top module: `sysbus_arbiter`

## Requirements
- R1: After reset `grant` is 0, `tmo_status` is 0, the timeout is disabled, no preference is set, and the deny bits of all four non-processor masters are set. Requester indices are 0 processor, 1 graphics 0, 2 graphics 1, 3 core bus, 4 expansion bus.
- R2: A grant is issued at the first clock edge where `grant` is 0 and at least one eligible master requests. An eligible master is one that is requesting and not denied. The grant is one-hot, goes to a requesting eligible master, and stays unchanged until `done` is sampled high. It is 0 from the following edge.
- R3: Deny bits are at `cfg_wdata` bit 6 (graphics 0), bit 4 (graphics 1), bit 2 (core bus) and bit 0 (expansion bus). A denied master is never granted, even when it is the only requester or the preferred one.
- R4: Preference bits are at bit 9 (processor), 7 (graphics 0), 5 (graphics 1), 3 (core bus) and 1 (expansion bus). Arbitrations alternate between preference turns and normal turns, and the first arbitration after reset is a preference turn. On a preference turn, an eligible preferred master is granted.
- R5: When several preference bits are set, only the master with the lowest requester index is treated as preferred.
- R6: On a normal turn, or on a preference turn with no eligible preferred master, the grant goes to the first eligible requester after the last granted index, in increasing order with wrap-around. The search after reset starts just after index 4.
- R7: The timeout is `cfg_wdata[28:16]`. If it is N > 0 and `done` does not arrive, the grant stays high for exactly N cycles, is then forced to 0, and `tmo_status` becomes 1.
- R8: A timeout value of 0 disables the timeout: a grant is held for as long as `done` stays low.
- R9: `tmo_status` stays set until a cycle with `stat_rd` high clears it. When a timeout and `stat_rd` fall in the same cycle, the flag stays set. A `done` that arrives before the limit leaves the flag clear.
- R10: A control word written with `cfg_we` governs every arbitration from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: deny, preference and timeout fields |
| req | input | 5 | Request lines, one per master |
| done | input | 1 | Current owner ends its transaction |
| stat_rd | input | 1 | Read strobe that clears the timeout flag |
| grant | output | 5 | One-hot bus grant |
| tmo_status | output | 1 | Sticky bus-error timeout flag |

## Verification
The checker verifies on every cycle that the grant is one-hot and goes to a requesting, non-denied master. It also checks that a grant stays stable until `done` or a timeout ends it. The same properties cover these points:
- an eligible preferred master wins its preference turn;
- a timeout ends the grant and sets the flag;
- a zero limit never times out;
- the flag rises only because of a timeout.

The round-robin order, the choice of the lowest of several preference bits, the exact grant length of N cycles, and the rule that a timeout wins over a read in the same cycle depend on sequences of transactions. Only the bench's directed scenarios show them.

// File: rtl/sysbus_arb_pkg.sv
package sysbus_arb_pkg;
  localparam int NREQ = 5;

  // isolate the lowest set bit
  function automatic logic [NREQ-1:0] lowest_bit(input logic [NREQ-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  // per-requester deny mask from the control word (processor cannot be denied)
  function automatic logic [NREQ-1:0] deny_of(input logic [31:0] w);
    return {w[0], w[2], w[4], w[6], 1'b0};
  endfunction

  // per-requester preference bits from the control word
  function automatic logic [NREQ-1:0] pref_of(input logic [31:0] w);
    return {w[1], w[3], w[5], w[7], w[9]};
  endfunction

  // first candidate strictly above the last grant, else wrap to the lowest
  function automatic logic [NREQ-1:0] rr_pick(input logic [NREQ-1:0] cand,
                                              input logic [NREQ-1:0] last);
    logic [NREQ-1:0] above;
    logic [NREQ-1:0] hi;
    above = ~((last << 1) - 1'b1);
    hi    = cand & above;
    return (hi != '0) ? lowest_bit(hi) : lowest_bit(cand);
  endfunction
endpackage

// File: rtl/sysbus_arb_cfg.sv
module sysbus_arb_cfg
  import sysbus_arb_pkg::*;
#(
  parameter int TMO_W   = 13,
  parameter int TMO_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [31:0]      wdata,
  output logic [NREQ-1:0]  deny_mask,
  output logic [NREQ-1:0]  pref_oh,
  output logic [TMO_W-1:0] tmo_limit
);
  logic [NREQ-1:0] deny_q;
  logic [NREQ-1:0] pref_q;
  logic [TMO_W-1:0] tmo_q;
  logic unused_wbits;

  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deny_q <= {{(NREQ-1){1'b1}}, 1'b0};
      pref_q <= '0;
      tmo_q  <= '0;
    end else if (we) begin
      deny_q <= deny_of(wdata);
      pref_q <= pref_of(wdata);
      tmo_q  <= wdata[TMO_LSB +: TMO_W];
    end
  end

  assign deny_mask = deny_q;
  assign pref_oh   = lowest_bit(pref_q);
  assign tmo_limit = tmo_q;
endmodule

// File: rtl/sysbus_arb_pick.sv
module sysbus_arb_pick
  import sysbus_arb_pkg::*;
(
  input  logic [NREQ-1:0] cand,
  input  logic [NREQ-1:0] last,
  input  logic [NREQ-1:0] pref_oh,
  input  logic            pref_turn,
  output logic [NREQ-1:0] pick,
  output logic            pref_win
);
  always_comb begin
    pref_win = pref_turn && ((pref_oh & cand) != '0);
    pick     = pref_win ? pref_oh : rr_pick(cand, last);
  end
endmodule

// File: rtl/sysbus_arb_timer.sv
module sysbus_arb_timer #(
  parameter int TMO_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic             done,
  input  logic             stat_rd,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo_hit,
  output logic             tmo_flag
);
  logic [TMO_W-1:0] cnt;

  assign tmo_hit = busy && !done && (limit != '0) && (cnt == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tmo_flag <= 1'b0;
    end else begin
      if (start)
        cnt <= '0;
      else if (busy && !done)
        cnt <= cnt + 1'b1;
      if (tmo_hit)
        tmo_flag <= 1'b1;
      else if (stat_rd)
        tmo_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
  import sysbus_arb_pkg::*;
#(
  parameter int TMO_W   = 13,
  parameter int TMO_LSB = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  input  logic [NREQ-1:0] req,
  input  logic            done,
  input  logic            stat_rd,
  output logic [NREQ-1:0] grant,
  output logic            tmo_status
);
  logic [NREQ-1:0]  deny_mask;
  logic [NREQ-1:0]  pref_oh;
  logic [TMO_W-1:0] tmo_limit;
  logic [NREQ-1:0]  cand;
  logic [NREQ-1:0]  pick;
  logic [NREQ-1:0]  last_q;
  logic             pref_turn;
  logic             pref_win;
  logic             arb_fire;
  logic             bus_busy;
  logic             tmo_hit;

  sysbus_arb_cfg #(.TMO_W(TMO_W), .TMO_LSB(TMO_LSB)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .deny_mask(deny_mask), .pref_oh(pref_oh), .tmo_limit(tmo_limit)
  );

  assign cand     = req & ~deny_mask;
  assign bus_busy = (grant != '0);
  assign arb_fire = !bus_busy && (cand != '0);

  sysbus_arb_pick u_pick (
    .cand(cand), .last(last_q), .pref_oh(pref_oh), .pref_turn(pref_turn),
    .pick(pick), .pref_win(pref_win)
  );

  sysbus_arb_timer #(.TMO_W(TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(arb_fire), .busy(bus_busy),
    .done(done), .stat_rd(stat_rd), .limit(tmo_limit),
    .tmo_hit(tmo_hit), .tmo_flag(tmo_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant     <= '0;
      last_q    <= NREQ'(1) << (NREQ-1);
      pref_turn <= 1'b1;
    end else if (arb_fire) begin
      grant     <= pick;
      last_q    <= pick;
      pref_turn <= ~pref_turn;
    end else if (bus_busy && (done || tmo_hit)) begin
      grant     <= '0;
    end
  end
endmodule

// File: rtl/sysbus_arbiter_chk.sv
module sysbus_arbiter_chk
  import sysbus_arb_pkg::*;
#(
  parameter int TMO_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req,
  input logic             done,
  input logic [NREQ-1:0]  grant,
  input logic             tmo_status,
  input logic             arb_fire,
  input logic             tmo_hit,
  input logic             pref_turn,
  input logic [NREQ-1:0]  pref_oh,
  input logic [NREQ-1:0]  deny_mask,
  input logic [TMO_W-1:0] tmo_limit
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    arb_fire |=> ((grant & $past(req)) != '0)); // R2

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && !done && !tmo_hit) |=> $stable(grant)); // R2

  AST_DENIED_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    arb_fire |=> ((grant & $past(deny_mask)) == '0)); // R3

  AST_PREF_TURN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_fire && pref_turn && ((pref_oh & req & ~deny_mask) != '0))
      |=> (grant == $past(pref_oh))); // R4

  AST_TMO_ENDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> ((grant == '0) && tmo_status)); // R7

  AST_TMO_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_limit == '0) |-> !tmo_hit); // R8

  AST_FLAG_FROM_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_status) |-> $past(tmo_hit)); // R9
endmodule

bind sysbus_arbiter sysbus_arbiter_chk #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done), .grant(grant),
  .tmo_status(tmo_status), .arb_fire(arb_fire), .tmo_hit(tmo_hit),
  .pref_turn(pref_turn), .pref_oh(pref_oh), .deny_mask(deny_mask),
  .tmo_limit(tmo_limit)
);

// File: tb/sysbus_arbiter_bench.sv
module sysbus_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [4:0]  req = '0;
  logic        done = 1'b0;
  logic        stat_rd = 1'b0;
  logic [4:0]  grant;
  logic        tmo_status;

  int n_checks = 0;
  int n_fails  = 0;

  // bench-side model state
  logic [4:0] deny_b;
  logic [4:0] pref_b;
  int         last_b;
  logic       turn_b;

  always #2 clk = ~clk;

  sysbus_arbiter u_sysbus_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .done(done), .stat_rd(stat_rd),
    .grant(grant), .tmo_status(tmo_status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] rr_model(input logic [4:0] cand, input int last);
    for (int k = 1; k <= 5; k++) begin
      int idx;
      idx = (last + k) % 5;
      if (cand[idx]) return 5'(1) << idx;
    end
    return '0;
  endfunction

  task automatic cfg_write(input logic [31:0] w);
    logic [4:0] praw;
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    deny_b = {w[0], w[2], w[4], w[6], 1'b0};
    praw   = {w[1], w[3], w[5], w[7], w[9]};
    pref_b = '0;
    for (int i = 4; i >= 0; i--) if (praw[i]) pref_b = 5'(1) << i;
  endtask

  task automatic note_grant(input logic [4:0] g);
    for (int i = 0; i < 5; i++) if (g[i]) last_b = i;
    turn_b = ~turn_b;
  endtask

  task automatic do_txn(input string tag, input logic [4:0] r);
    logic [4:0] cand;
    logic [4:0] exp;
    cand = r & ~deny_b;
    exp  = (turn_b && ((pref_b & cand) != '0)) ? pref_b : rr_model(cand, last_b);
    req = r;
    @(negedge clk);
    check(tag, grant, exp);
    if (exp != '0) note_grant(exp);
    req = '0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check({tag, " release"}, grant, 5'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    deny_b = 5'b11110; pref_b = '0; last_b = 4; turn_b = 1'b1;
    check("R1 grant after reset", grant, 5'b0);
    check("R1 status after reset", tmo_status, 1'b0);
    do_txn("R1 only processor eligible", 5'b11111);
  endtask

  task automatic t_deny();
    cfg_write(32'h0000_0055);
    req = 5'b00010;
    repeat (3) begin
      @(negedge clk);
      check("R3 lone denied requester", grant, 5'b0);
    end
    req = '0;
    cfg_write(32'h0000_0003); // deny + prefer expansion bus
    req = 5'b10000;
    repeat (3) begin
      @(negedge clk);
      check("R3 denied preferred requester", grant, 5'b0);
    end
    req = '0;
    do_txn("R3 processor alongside denied", 5'b10001);
  endtask

  task automatic t_round_robin();
    cfg_write(32'h0);
    check("R10 write applied", grant, 5'b0);
    for (int i = 0; i < 6; i++) do_txn("R6 rotation all requesting", 5'b11111);
    do_txn("R6 sparse wrap", 5'b10001);
    do_txn("R6 sparse wrap", 5'b10001);
    do_txn("R6 sparse mid", 5'b01010);
  endtask

  task automatic t_preference();
    cfg_write(32'h0000_0008); // prefer core bus
    for (int i = 0; i < 6; i++) do_txn("R4 alternating preference", 5'b11111);
    do_txn("R4 preferred idle", 5'b00011);
  endtask

  task automatic t_multi_pref();
    cfg_write(32'h0000_0202); // processor and expansion both preferred
    for (int i = 0; i < 4; i++) do_txn("R5 lowest index preferred", 5'b10001);
  endtask

  task automatic t_timeout();
    cfg_write(32'd5 << 16);
    req = 5'b00001;
    @(negedge clk);
    check("R7 grant issued", grant, 5'b00001);
    note_grant(5'b00001);
    for (int k = 2; k <= 5; k++) begin
      @(negedge clk);
      check("R7 grant held until limit", grant, 5'b00001);
    end
    req = '0;
    @(negedge clk);
    check("R7 grant forced off", grant, 5'b0);
    check("R7 flag set", tmo_status, 1'b1);
    repeat (3) @(negedge clk);
    check("R9 flag sticky", tmo_status, 1'b1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R9 flag cleared by read", tmo_status, 1'b0);

    cfg_write(32'd2 << 16);
    req = 5'b00001;
    @(negedge clk);
    note_grant(5'b00001);
    req = '0;
    @(negedge clk);
    check("R7 short limit held", grant, 5'b00001);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R9 timeout wins over read", tmo_status, 1'b1);
    check("R7 short limit dropped", grant, 5'b0);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;

    cfg_write(32'd3 << 16);
    req = 5'b00001;
    @(negedge clk);
    note_grant(5'b00001);
    req = '0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check("R9 early done ends grant", grant, 5'b0);
    repeat (4) @(negedge clk);
    check("R9 early done no flag", tmo_status, 1'b0);
  endtask

  task automatic t_timeout_off();
    cfg_write(32'h0);
    req = 5'b00001;
    @(negedge clk);
    note_grant(5'b00001);
    req = '0;
    repeat (20) @(negedge clk);
    check("R8 zero limit keeps grant", grant, 5'b00001);
    check("R8 zero limit no flag", tmo_status, 1'b0);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    check("R8 done releases", grant, 5'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_deny();
    t_round_robin();
    t_preference();
    t_multi_pref();
    t_timeout();
    t_timeout_off();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule